// File: doc/BRIEF.md
# Sector Check-Word Engine

This engine folds a fixed-length sector of 16-bit words into a 16-bit check value. A disk controller presents the sector's words one at a time over a valid/ready handshake, after a read or a compare pass. When the final word has been absorbed, the engine raises a one-cycle completion pulse. The result is then held for loading into the controller's data-buffer register.

The update is reflected, so bits enter least significant first, and it uses the feedback constant 0xA001. A parameter sets how many bits are absorbed per clock. It can be one bit per cycle, which is the smallest logic, or the whole word in a single cycle, which gives full throughput. Any divisor of 16 in between is also allowed. The result does not depend on this choice. A start pulse clears the register and the word count at any time, including in the middle of a sector.

Top module: `sector_crc_engine`

## Requirements
- R1: After reset, `crc_o` is 0, `word_rdy_o` is 1 and `done_o` is 0.
- R2: A cycle with `start_i` high clears the check value to 0 and clears the word count. On the next cycle `crc_o` is 0, `done_o` is 0 and `word_rdy_o` is 1. A word offered in the same cycle as `start_i` is not absorbed.
- R3: For each absorbed data bit d, bit 0 of the register is replaced by its XOR with d. The register then shifts right by one. If that new bit 0 was 1 before the shift, the shifted value is XORed with 0xA001.
- R4: Each word's bits are absorbed in order from bit 0 up to bit 15.
- R5: A sector is exactly SECTOR_WORDS words (32 by default). `done_o` is high for exactly one cycle, the cycle right after the last bit of the final word is absorbed. In that cycle `crc_o` shows the sector's check value.
- R6: A word is taken on a clock edge where `word_vld_i` and `word_rdy_o` are both high. After that edge, `word_rdy_o` stays low for 16/STEP_BITS − 1 cycles. A `word_vld_i` during those cycles is ignored.
- R7: After the final word of a sector, `word_rdy_o` stays low and `crc_o` holds its value until the next start. Words offered in that time have no effect.
- R8: STEP_BITS of 1 and STEP_BITS of 16 give identical check values for the same sector.
- R9: While the engine is ready and no word or start is offered, `crc_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clear and begin a new sector |
| word_vld_i | input | 1 | A data word is offered |
| word_i | input | 16 | Data word |
| word_rdy_o | output | 1 | Engine can take a word this cycle |
| done_o | output | 1 | One-cycle pulse: the sector is complete |
| crc_o | output | 16 | Running or final check value |

## Verification
The bench builds two copies side by side. One has STEP_BITS = 1, so a word takes sixteen cycles and the ready line drops for fifteen of them. The other has STEP_BITS = 16, so the whole word is absorbed in one cycle. Both receive the same sectors: all zeros, a single set bit, and random data. This lets the result of the serial chain be compared with the unrolled one. It also exposes the busy-window case, which only the serial copy has: words are held on its valid line while it shifts, and these must be ignored. A restart in the middle of a sector, a start that coincides with a word, and words offered after completion are applied to both copies.

// File: rtl/sec_crc_pkg.sv
package sec_crc_pkg;
  localparam int CRC_W = 16;

  // one reflected update step for a single data bit
  function automatic logic [CRC_W-1:0] crc_bit_step(
    input logic [CRC_W-1:0] cur,
    input logic             din,
    input logic [CRC_W-1:0] poly
  );
    logic fb;
    fb = cur[0] ^ din;
    crc_bit_step = {1'b0, cur[CRC_W-1:1]} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/crc_chunk_update.sv
module crc_chunk_update
  import sec_crc_pkg::*;
#(
  parameter int               STEP_BITS = 1,
  parameter logic [CRC_W-1:0] POLY      = 16'hA001
) (
  input  logic [CRC_W-1:0]     crc_i,
  input  logic [STEP_BITS-1:0] bits_i,
  output logic [CRC_W-1:0]     crc_o
);
  logic [CRC_W-1:0] chain [STEP_BITS+1];

  assign chain[0] = crc_i;

  // bit 0 first, chained one step per bit
  for (genvar b = 0; b < STEP_BITS; b++) begin : g_step
    assign chain[b+1] = crc_bit_step(chain[b], bits_i[b], POLY);
  end

  assign crc_o = chain[STEP_BITS];
endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl #(
  parameter int NCHUNK       = 16,
  parameter int SECTOR_WORDS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic vld_i,
  output logic accept_o,
  output logic shift_o,
  output logic rdy_o,
  output logic done_o
);
  localparam int CW  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
  localparam int WCW = (SECTOR_WORDS > 1) ? $clog2(SECTOR_WORDS) : 1;
  localparam logic [CW-1:0]  CHUNK_RELOAD = CW'(NCHUNK - 1);
  localparam logic [WCW-1:0] LAST_WORD    = WCW'(SECTOR_WORDS - 1);

  logic [CW-1:0]  left_q, left_n;
  logic [WCW-1:0] wcnt_q, wcnt_n;
  logic           full_q, full_n;
  logic           done_q, done_n;
  logic           word_end;

  assign rdy_o    = !full_q && (left_q == '0);
  assign accept_o = vld_i && rdy_o && !start_i;
  assign shift_o  = (left_q != '0) && !start_i;
  assign word_end = (accept_o && (NCHUNK == 1)) ||
                    (shift_o && (left_q == CW'(1)));
  assign done_o   = done_q;

  always_comb begin
    left_n = left_q;
    wcnt_n = wcnt_q;
    full_n = full_q;
    done_n = 1'b0;
    if (start_i) begin
      left_n = '0;
      wcnt_n = '0;
      full_n = 1'b0;
    end else begin
      if (accept_o)     left_n = CHUNK_RELOAD;
      else if (shift_o) left_n = left_q - CW'(1);
      if (word_end) begin
        if (wcnt_q == LAST_WORD) begin
          full_n = 1'b1;
          done_n = 1'b1;
          wcnt_n = '0;
        end else begin
          wcnt_n = wcnt_q + WCW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      wcnt_q <= '0;
      full_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      left_q <= left_n;
      wcnt_q <= wcnt_n;
      full_q <= full_n;
      done_q <= done_n;
    end
  end

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7: after completion no word is taken
  p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rdy_o);
endmodule

// File: rtl/sector_crc_engine.sv
module sector_crc_engine
  import sec_crc_pkg::*;
#(
  parameter int               STEP_BITS    = 1,
  parameter int               SECTOR_WORDS = 32,
  parameter logic [CRC_W-1:0] POLY         = 16'hA001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             word_vld_i,
  input  logic [CRC_W-1:0] word_i,
  output logic             word_rdy_o,
  output logic             done_o,
  output logic [CRC_W-1:0] crc_o
);
  localparam int NCHUNK = CRC_W / STEP_BITS;

  logic                 accept, shift;
  logic [CRC_W-1:0]     crc_q, crc_n, crc_step;
  logic [CRC_W-1:0]     shreg_q, shreg_n;
  logic [STEP_BITS-1:0] chunk;

  crc_seq_ctrl #(
    .NCHUNK      (NCHUNK),
    .SECTOR_WORDS(SECTOR_WORDS)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .vld_i   (word_vld_i),
    .accept_o(accept),
    .shift_o (shift),
    .rdy_o   (word_rdy_o),
    .done_o  (done_o)
  );

  // the first chunk comes straight from the port, the rest from the shifter
  assign chunk = accept ? word_i[STEP_BITS-1:0] : shreg_q[STEP_BITS-1:0];

  crc_chunk_update #(
    .STEP_BITS(STEP_BITS),
    .POLY     (POLY)
  ) u_upd (
    .crc_i (crc_q),
    .bits_i(chunk),
    .crc_o (crc_step)
  );

  always_comb begin
    crc_n   = crc_q;
    shreg_n = shreg_q;
    if (start_i) begin
      crc_n = '0;
    end else if (accept) begin
      crc_n   = crc_step;
      shreg_n = word_i >> STEP_BITS;
    end else if (shift) begin
      crc_n   = crc_step;
      shreg_n = shreg_q >> STEP_BITS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q   <= '0;
      shreg_q <= '0;
    end else begin
      crc_q   <= crc_n;
      shreg_q <= shreg_n;
    end
  end

  assign crc_o = crc_q;

  // R2: a start leaves a clean, ready engine
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (crc_o == '0) && !done_o && word_rdy_o);
  // R9: nothing offered, nothing changes
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !word_vld_i && word_rdy_o) |=> $stable(crc_o));

  if (NCHUNK > 1) begin : g_busy_chk
    // R6: a taken word closes the ready window while it is shifted in
    p_busy_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld_i && word_rdy_o && !start_i) |=> !word_rdy_o);
  end
endmodule

// File: tb/sim_sector_crc_engine.sv
module sim_sector_crc_engine;
  logic        clk, rst_n, start, vld0, vld1;
  logic [15:0] data;
  logic        rdy0, rdy1, done0, done1;
  logic [15:0] crc0, crc1;

  int n_chk = 0, n_fail = 0;
  logic [15:0] secbuf [32];
  logic [15:0] q0 [$];
  logic [15:0] q1 [$];
  logic [15:0] last_exp;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  sector_crc_engine #(.STEP_BITS(1)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .word_vld_i(vld0), .word_i(data),
    .word_rdy_o(rdy0), .done_o(done0), .crc_o(crc0));

  sector_crc_engine #(.STEP_BITS(16)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .word_vld_i(vld1), .word_i(data),
    .word_rdy_o(rdy1), .done_o(done1), .crc_o(crc1));

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: reflected update, bit 0 first (R3, R4)
  function automatic logic [15:0] ref_word(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r;
    r = c;
    for (int b = 0; b < 16; b++) begin
      r[0] = r[0] ^ w[b];
      if (r[0]) r = (r >> 1) ^ 16'hA001;
      else      r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] ref_sector();
    logic [15:0] c;
    c = '0;
    for (int i = 0; i < 32; i++) c = ref_word(c, secbuf[i]);
    return c;
  endfunction

  // monitors: each completion pops the expected value (R5, R8)
  always @(negedge clk) begin
    if (rst_n && done0) begin
      if (q0.size() == 0) chk(1'b0, "R5 u0 unexpected done", crc0, 16'h0);
      else begin
        logic [15:0] e;
        e = q0.pop_front();
        chk(crc0 == e, "R5 R8 u0 sector value", crc0, e);
      end
    end
    if (rst_n && done1) begin
      if (q1.size() == 0) chk(1'b0, "R5 u1 unexpected done", crc1, 16'h0);
      else begin
        logic [15:0] e;
        e = q1.pop_front();
        chk(crc1 == e, "R5 R8 u1 sector value", crc1, e);
      end
    end
  end

  task automatic send(input logic [15:0] w);
    while (!(rdy0 && rdy1)) @(negedge clk);
    vld0 = 1'b1; vld1 = 1'b1; data = w;
    @(negedge clk);
    vld0 = 1'b0; vld1 = 1'b0;
  endtask

  // R6: keep offering junk to the serial copy while it is busy
  task automatic send_noisy(input logic [15:0] w);
    while (!(rdy0 && rdy1)) @(negedge clk);
    vld0 = 1'b1; vld1 = 1'b1; data = w;
    @(negedge clk);
    vld1 = 1'b0; data = ~w;
    chk(rdy0 == 1'b0, "R6 u0 busy after take", {15'b0, rdy0}, 16'h0);
    for (int k = 0; k < 8; k++) @(negedge clk);
    vld0 = 1'b0;
  endtask

  task automatic run_sector(input bit noisy);
    last_exp = ref_sector();
    q0.push_back(last_exp);
    q1.push_back(last_exp);
    for (int i = 0; i < 32; i++) begin
      if (noisy && (i % 7 == 3)) send_noisy(secbuf[i]);
      else send(secbuf[i]);
    end
    for (int k = 0; k < 20; k++) @(negedge clk);
    chk(crc0 == last_exp, "R7 u0 hold after sector", crc0, last_exp);
    chk(crc1 == last_exp, "R8 u1 hold after sector", crc1, last_exp);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; vld0 = 1'b0; vld1 = 1'b0; data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(crc0 == 16'h0 && crc1 == 16'h0, "R1 reset value", crc0 | crc1, 16'h0);
    chk(rdy0 && rdy1, "R1 reset ready", {14'b0, rdy0, rdy1}, 16'h3);
    chk(!done0 && !done1, "R1 reset done", {14'b0, done0, done1}, 16'h0);
    // R9: idle keeps value
    repeat (4) @(negedge clk);
    chk(crc0 == 16'h0 && crc1 == 16'h0, "R9 idle stable", crc0 | crc1, 16'h0);

    // all-zero sector
    for (int i = 0; i < 32; i++) secbuf[i] = 16'h0;
    run_sector(1'b0);

    // R7: words after completion are ignored
    vld0 = 1'b1; vld1 = 1'b1; data = 16'hBEEF;
    repeat (3) @(negedge clk);
    vld0 = 1'b0; vld1 = 1'b0;
    chk(!rdy0 && !rdy1, "R7 not ready after sector", {14'b0, rdy0, rdy1}, 16'h0);
    chk(crc0 == last_exp && crc1 == last_exp, "R7 value unchanged", crc1, last_exp);

    // single-bit sector (R3, R4)
    pulse_start();
    chk(crc0 == 16'h0 && rdy0 && rdy1, "R2 cleared by start", crc0, 16'h0);
    for (int i = 0; i < 32; i++) secbuf[i] = 16'h0;
    secbuf[0] = 16'h0001;
    run_sector(1'b0);
    pulse_start();
    for (int i = 0; i < 32; i++) secbuf[i] = 16'h0;
    secbuf[31] = 16'h8000;
    run_sector(1'b0);

    // random sectors, one with busy-window noise (R6)
    for (int s = 0; s < 3; s++) begin
      pulse_start();
      for (int i = 0; i < 32; i++) secbuf[i] = 16'($urandom);
      run_sector(s == 1);
    end

    // R2: restart mid-sector, with a word offered on the start cycle
    pulse_start();
    for (int i = 0; i < 10; i++) send(16'($urandom));
    while (!(rdy0 && rdy1)) @(negedge clk);
    start = 1'b1; vld0 = 1'b1; vld1 = 1'b1; data = 16'h1234;
    @(negedge clk);
    start = 1'b0; vld0 = 1'b0; vld1 = 1'b0;
    chk(crc0 == 16'h0 && crc1 == 16'h0, "R2 restart clears", crc0 | crc1, 16'h0);
    for (int i = 0; i < 32; i++) secbuf[i] = 16'($urandom);
    run_sector(1'b0);

    chk(q0.size() == 0 && q1.size() == 0, "R5 all completions seen",
        16'(q0.size() + q1.size()), 16'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h1, 16'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule